// File: doc/BRIEF.md
# Double-Buffered Serial Port with Address-Bit Wake-Up Filter

This block is one asynchronous serial channel for a microcontroller peripheral bus. Transmit data goes through a holding register into a shift register, so software can queue the next byte while the current one is still on the line. Received frames land in a small FIFO, and software reads the oldest byte first. The line rate comes from a single-cycle `baud_tick` enable that is pulsed at sixteen times the bit rate.

There is an optional frame format with one extra bit per frame. Several nodes on a shared line use that bit to tell address frames (bit = 1) from data frames (bit = 0). When the wake-up filter is on, frames whose extra bit is 0 are dropped before they reach the FIFO or any flag. Software sees four byte-wide registers: transmit data at address 0, receive data at address 1 (a read strobe pops the FIFO), control at address 2 and status at address 3. A control write with bit 4 at 0 clears the error flags. A control read returns in bit 4 the extra bit of the last accepted frame.

Top module: `mpuart`

## Requirements
- R1: A write to address 0 loads the transmit holding register. When the shifter is idle and transmission is enabled, the byte moves into the shifter within two cycles, and status bit 1 (transmit empty) reads 1 again while that frame is still being sent. A second write during that frame is held, and status bit 1 reads 0.
- R2: When a frame ends and a byte is held, the next frame starts within two clock cycles of the end of the stop bit.
- R3: `txd` is 1 whenever no frame is being sent.
- R4: A frame is a start bit (0), 8 data bits sent least significant bit first, an extra bit equal to control bit 5 when control bit 2 (extended format) is 1, and a stop bit (1). Each bit lasts 16 `baud_tick` pulses. The receiver samples each bit near its middle.
- R5: Received bytes go into a 4-entry FIFO. A read of address 1 with `reg_rd` returns the oldest byte and pops it. Status bit 0 is 1 while the FIFO holds data, and status bit 6 is 1 when it holds 4 bytes.
- R6: An accepted frame that completes while the FIFO holds 4 bytes sets status bit 2 (overrun). The new byte is discarded and the stored bytes are kept.
- R7: An accepted frame whose stop bit is sampled as 0 sets status bit 3 (framing error). Its byte is still stored in the FIFO.
- R8: When control bits 2 and 3 (wake-up filter) are both 1, a frame with extra bit 0 is discarded. It does not enter the FIFO and sets no status flag.
- R9: When control bit 3 is 0, every frame is accepted, whatever its extra bit.
- R10: When control bit 1 (transmit enable) is cleared, the frame in progress is aborted and `txd` goes to 1 at once. Status bit 1 keeps its previous value, and a held byte is sent after transmission is enabled again.
- R11: An accepted frame with all data bits 0, extra bit 0 and stop bit 0 sets status bit 5 (break). A control write with bit 4 at 0 clears status bits 2, 3 and 5.
- R12: A control read returns in bit 4 the extra bit of the last accepted frame while control bit 2 is 1, and 0 otherwise.
- R13: After reset, the control register reads 0x00 (receive enable bit 0, transmit enable bit 1, extended format, wake-up filter all 0), status reads 0x02, and `txd` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| baud_tick | input | 1 | One-cycle enable at 16x the bit rate |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe; pops the FIFO at address 1 |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |

## Verification
The bench checks that a second byte written while the first is being sent goes out right after it, with no idle bit between them. A design without the holding stage would drop that byte or leave a gap. It sends five frames into an empty FIFO and expects the four oldest bytes back with the overrun flag set. A design that overwrites or shifts out stored data would return wrong bytes. It sends a frame with extra bit 0 and a bad stop bit while the filter is on, and expects neither a stored byte nor a framing flag, so a design that filters only the data path and not the flags is caught. Last, it clears transmit enable in the middle of a frame with a byte still held, and expects the line to go high at once, the empty flag to stay at 0, and the held byte to be sent after transmission is enabled again.

// File: rtl/mpuart_pkg.sv
// Shared register map, control/status bit positions and receive frame type.
package mpuart_pkg;
    localparam logic [1:0] A_TXD  = 2'd0;
    localparam logic [1:0] A_RXD  = 2'd1;
    localparam logic [1:0] A_CTRL = 2'd2;
    localparam logic [1:0] A_STAT = 2'd3;

    localparam int C_RXEN = 0;
    localparam int C_TXEN = 1;
    localparam int C_MP   = 2;
    localparam int C_WAKE = 3;
    localparam int C_ERST = 4;
    localparam int C_TMPB = 5;

    typedef struct packed {
        logic [7:0] data;
        logic       mpb;
        logic       ferr;
        logic       brk;
    } rx_frame_t;
endpackage

// File: rtl/mpuart_fifo.sv
// Receive FIFO. Assumes the caller pushes only when not full and pops only when not empty.
module mpuart_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Storage write
    always_ff @(posedge clk) begin
        if (push) mem[wp] <= din;
    end

    // Pointers and occupancy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp <= '0; rp <= '0; count <= '0;
        end else begin
            if (push) wp <= nxt(wp);
            if (pop)  rp <= nxt(rp);
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign dout  = mem[rp];
    assign full  = (count == CW'(DEPTH));
    assign empty = (count == '0);
endmodule

// File: rtl/mpuart_tx.sv
// Transmitter: holding register plus shift register. Assumes baud_tick is a
// one-cycle pulse at OSR times the bit rate. en low aborts the frame at once.
module mpuart_tx #(
    parameter int OSR = 16,
    localparam int TW = $clog2(OSR)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       baud_tick,
    input  logic       en,
    input  logic       mp,
    input  logic       mpb,
    input  logic       wr,
    input  logic [7:0] wdata,
    output logic       txd,
    output logic       empty,
    output logic       busy
);
    logic [7:0]  thr;
    logic        full;
    logic [10:0] sh;
    logic [3:0]  left;
    logic [TW-1:0] cnt;
    logic        load;

    assign load = en && !busy && full;

    // Holding register and its occupancy flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr <= '0; full <= 1'b0;
        end else begin
            if (wr) thr <= wdata;
            if (wr) full <= 1'b1;
            else if (load) full <= 1'b0;
        end
    end

    // Shift register, bit timing and frame length
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh <= '1; left <= '0; cnt <= '0; busy <= 1'b0;
        end else if (!en) begin
            busy <= 1'b0; cnt <= '0;
        end else if (load) begin
            busy <= 1'b1; cnt <= '0;
            sh   <= mp ? {1'b1, mpb, thr, 1'b0} : {2'b11, thr, 1'b0};
            left <= mp ? 4'd11 : 4'd10;
        end else if (busy && baud_tick) begin
            if (cnt == TW'(OSR - 1)) begin
                cnt  <= '0;
                sh   <= {1'b1, sh[10:1]};
                left <= left - 1'b1;
                if (left == 4'd1) busy <= 1'b0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign txd   = (busy && en) ? sh[0] : 1'b1;
    assign empty = !full;
endmodule

// File: rtl/mpuart_rx.sv
// Receiver: synchronises rxd, finds the start bit, samples each bit mid-cell
// and reports one frame per done pulse. Assumes mp is stable during a frame.
module mpuart_rx
    import mpuart_pkg::*;
#(
    parameter int OSR = 16,
    localparam int TW = $clog2(OSR)
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      baud_tick,
    input  logic      en,
    input  logic      mp,
    input  logic      rxd,
    output logic      done,
    output rx_frame_t frame
);
    typedef enum logic [1:0] {S_IDLE, S_START, S_BITS} rx_st_t;
    rx_st_t        st;
    logic [1:0]    sync;
    logic          rx_s;
    logic [TW-1:0] cnt;
    logic [3:0]    idx, last;
    logic [9:0]    bits;
    logic          mpb_v;

    assign rx_s  = sync[1];
    assign last  = mp ? 4'd9 : 4'd8;
    assign mpb_v = mp & bits[8];

    // Two-flop synchroniser for the line
    always_ff @(posedge clk) begin
        if (!rst_n) sync <= 2'b11;
        else        sync <= {sync[0], rxd};
    end

    // Start detection, mid-bit sampling and frame hand-off
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= S_IDLE; cnt <= '0; idx <= '0; bits <= '0;
            done <= 1'b0; frame <= '0;
        end else begin
            done <= 1'b0;
            if (!en) begin
                st <= S_IDLE;
            end else if (baud_tick) begin
                case (st)
                    S_IDLE: if (!rx_s) begin st <= S_START; cnt <= '0; end
                    S_START: begin
                        if (cnt == TW'(OSR / 2 - 1)) begin
                            cnt <= '0; idx <= '0;
                            st  <= rx_s ? S_IDLE : S_BITS;
                        end else cnt <= cnt + 1'b1;
                    end
                    S_BITS: begin
                        if (cnt == TW'(OSR - 1)) begin
                            cnt <= '0;
                            bits[idx] <= rx_s;
                            if (idx == last) begin
                                done       <= 1'b1;
                                st         <= S_IDLE;
                                frame.data <= bits[7:0];
                                frame.mpb  <= mpb_v;
                                frame.ferr <= !rx_s;
                                frame.brk  <= !rx_s && !mpb_v && (bits[7:0] == 8'h00);
                            end else idx <= idx + 1'b1;
                        end else cnt <= cnt + 1'b1;
                    end
                    default: st <= S_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/mpuart.sv
// Serial channel top: register file, wake-up filter, error flags, FIFO glue.
// Assumes reg_rd pops only at the receive data address; rdata is combinational.
module mpuart
    import mpuart_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int OSR   = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       baud_tick,
    input  logic       rxd,
    output logic       txd,
    input  logic [1:0] reg_addr,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata
);
    logic rx_en, tx_en, mp_fmt, wake_en, tx_mpb;
    logic ovr_flag, ferr_flag, brk_flag, last_mpb;
    logic tx_empty, tx_busy, fr_done, acc, push, pop, wr_ctrl;
    logic fr_mpb, fr_ferr;
    logic fifo_full, fifo_empty;
    logic [CW-1:0] fifo_count;
    logic [7:0] fifo_dout;
    rx_frame_t fr;

    assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);
    assign pop     = reg_rd && (reg_addr == A_RXD) && !fifo_empty;
    assign fr_mpb  = fr.mpb;
    assign fr_ferr = fr.ferr;
    assign acc     = !(mp_fmt && wake_en) || fr.mpb;
    assign push    = fr_done && acc && !fifo_full;

    // Control register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {rx_en, tx_en, mp_fmt, wake_en, tx_mpb} <= '0;
        end else if (wr_ctrl) begin
            rx_en   <= reg_wdata[C_RXEN];
            tx_en   <= reg_wdata[C_TXEN];
            mp_fmt  <= reg_wdata[C_MP];
            wake_en <= reg_wdata[C_WAKE];
            tx_mpb  <= reg_wdata[C_TMPB];
        end
    end

    // Error flags and last extra bit; a new event wins over a clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {ovr_flag, ferr_flag, brk_flag, last_mpb} <= '0;
        end else begin
            if (wr_ctrl && !reg_wdata[C_ERST]) {ovr_flag, ferr_flag, brk_flag} <= '0;
            if (fr_done && acc) begin
                last_mpb <= fr.mpb;
                if (fifo_full) ovr_flag  <= 1'b1;
                if (fr.ferr)   ferr_flag <= 1'b1;
                if (fr.brk)    brk_flag  <= 1'b1;
            end
        end
    end

    // Read data multiplexer
    always_comb begin
        case (reg_addr)
            A_RXD:   reg_rdata = fifo_dout;
            A_CTRL:  reg_rdata = {2'b00, tx_mpb, mp_fmt & last_mpb, wake_en, mp_fmt, tx_en, rx_en};
            A_STAT:  reg_rdata = {1'b0, fifo_full, brk_flag, 1'b0, ferr_flag, ovr_flag, tx_empty, !fifo_empty};
            default: reg_rdata = 8'h00;
        endcase
    end

    mpuart_tx #(.OSR(OSR)) u_tx (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .en(tx_en), .mp(mp_fmt),
        .mpb(tx_mpb), .wr(reg_wr && (reg_addr == A_TXD)), .wdata(reg_wdata),
        .txd(txd), .empty(tx_empty), .busy(tx_busy)
    );

    mpuart_rx #(.OSR(OSR)) u_rx (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .en(rx_en), .mp(mp_fmt),
        .rxd(rxd), .done(fr_done), .frame(fr)
    );

    mpuart_fifo #(.W(8), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .din(fr.data), .pop(pop),
        .dout(fifo_dout), .count(fifo_count), .full(fifo_full), .empty(fifo_empty)
    );
endmodule

// File: rtl/mpuart_chk.sv
// Property checker for mpuart, attached by bind. Observes only; drives nothing.
module mpuart_chk #(
    parameter int DEPTH = 4,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          txd,
    input logic          tx_en,
    input logic          tx_busy,
    input logic [CW-1:0] fifo_count,
    input logic          fifo_full,
    input logic          fr_done,
    input logic          fr_mpb,
    input logic          fr_ferr,
    input logic          acc,
    input logic          mp_fmt,
    input logic          wake_en,
    input logic          ovr_flag,
    input logic          ferr_flag
);
    p_txd_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> txd);
    p_abort_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |-> txd);
    p_fifo_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_count <= CW'(DEPTH));
    p_overrun_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_done && acc && fifo_full) |=> ovr_flag);
    p_framing_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_done && acc && fr_ferr) |=> ferr_flag);
    p_wake_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_done && mp_fmt && wake_en && !fr_mpb) |=> (!$rose(ferr_flag) && !$rose(ovr_flag)));
endmodule

bind mpuart mpuart_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .txd(txd), .tx_en(tx_en), .tx_busy(tx_busy),
    .fifo_count(fifo_count), .fifo_full(fifo_full), .fr_done(fr_done),
    .fr_mpb(fr_mpb), .fr_ferr(fr_ferr), .acc(acc), .mp_fmt(mp_fmt),
    .wake_en(wake_en), .ovr_flag(ovr_flag), .ferr_flag(ferr_flag)
);

// File: tb/test_mpuart.sv
// Scoreboard bench: driver tasks queue expected bytes, a line monitor and a
// register reader pop and compare them.
module test_mpuart;
    logic clk = 1'b0, rst_n = 1'b0, baud_tick = 1'b0, rxd = 1'b1;
    logic txd, reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'h00, reg_rdata;
    int checks = 0, fails = 0, cyc = 0;
    int last_start = 0, prev_start = 0;
    bit mon_en = 1'b1, exp_mp = 1'b0;
    logic [8:0] tx_q[$];
    logic [7:0] rx_q[$];
    logic [7:0] v;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) baud_tick <= (cyc % 2 == 1);

    mpuart i_mpuart (.clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rxd(rxd), .txd(txd),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk); #1 reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input bit popit, output logic [7:0] d);
        @(negedge clk); reg_addr = a; reg_rd = popit; #1 d = reg_rdata;
        @(posedge clk); #1 reg_rd = 1'b0;
    endtask

    // control write; bit 4 kept at 1 so errors stay unless erst is 0
    task automatic set_ctrl(input bit rxe, input bit txe, input bit mp, input bit wk, input bit tmpb, input bit erst_keep);
        exp_mp = mp;
        wr(2'd2, {2'b00, tmpb, erst_keep, wk, mp, txe, rxe});
    endtask

    task automatic send_frame(input logic [7:0] d, input bit mpbit, input bit stopv, input bit mp);
        @(negedge clk); rxd = 1'b0; repeat (32) @(negedge clk);
        for (int i = 0; i < 8; i++) begin rxd = d[i]; repeat (32) @(negedge clk); end
        if (mp) begin rxd = mpbit; repeat (32) @(negedge clk); end
        rxd = stopv; repeat (32) @(negedge clk);
        rxd = 1'b1; repeat (32) @(negedge clk);
    endtask

    task automatic read_rx(input string req);
        logic [7:0] d, e;
        rd(2'd1, 1'b1, d);
        e = (rx_q.size() > 0) ? rx_q.pop_front() : 8'hxx;
        chk(req, d, e);
    endtask

    // transmit line monitor: decodes each frame and compares with the queue
    initial forever begin
        logic [7:0] d; logic mb, sb;
        @(negedge txd);
        if (!mon_en) continue;
        prev_start = last_start; last_start = cyc;
        mb = 1'b0;
        repeat (16) @(negedge clk);
        chk("R4 start bit", txd, 1'b0);
        for (int i = 0; i < 8; i++) begin repeat (32) @(negedge clk); d[i] = txd; end
        if (exp_mp) begin repeat (32) @(negedge clk); mb = txd; end
        repeat (32) @(negedge clk); sb = txd;
        chk("R4 stop bit", sb, 1'b1);
        if (tx_q.size() == 0) chk("R4 unexpected frame", {mb, d}, 9'h1ff);
        else chk("R4 frame content", {mb, d}, tx_q.pop_front());
    end

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk); rst_n = 1'b1;
        rd(2'd2, 1'b0, v); chk("R13 ctrl reset", v, 8'h00);
        rd(2'd3, 1'b0, v); chk("R13 status reset", v, 8'h02);
        chk("R13 txd reset", txd, 1'b1);

        // R1 / R2: double buffering and back-to-back frames
        set_ctrl(1, 1, 0, 0, 0, 1);
        tx_q.push_back({1'b0, 8'hA5}); wr(2'd0, 8'hA5);
        repeat (4) @(negedge clk);
        rd(2'd3, 1'b0, v); chk("R1 empty while shifting", v[1], 1'b1);
        tx_q.push_back({1'b0, 8'h3C}); wr(2'd0, 8'h3C);
        rd(2'd3, 1'b0, v); chk("R1 held byte", v[1], 1'b0);
        repeat (800) @(negedge clk);
        chk("R2 both frames sent", tx_q.size(), 0);
        chk("R2 no gap", ((last_start - prev_start) >= 320 && (last_start - prev_start) <= 322), 1'b1);
        begin
            bit hi = 1'b1;
            for (int i = 0; i < 60; i++) begin @(negedge clk); hi &= txd; end
            chk("R3 idle high", hi, 1'b1);
        end

        // R4: extended format carries control bit 5
        set_ctrl(1, 1, 1, 0, 1, 1);
        tx_q.push_back({1'b1, 8'h81}); wr(2'd0, 8'h81);
        repeat (420) @(negedge clk);
        chk("R4 extended frame sent", tx_q.size(), 0);
        set_ctrl(1, 1, 0, 0, 0, 1);

        // R5: FIFO order
        foreach (rx_q[i]) ;
        for (int i = 1; i <= 3; i++) begin rx_q.push_back(8'(i * 8'h11)); send_frame(8'(i * 8'h11), 0, 1, 0); end
        for (int i = 0; i < 3; i++) read_rx("R5 fifo order");
        rd(2'd3, 1'b0, v); chk("R5 fifo drained", v[0], 1'b0);

        // R6: overrun keeps the four oldest bytes
        for (int i = 0; i < 5; i++) begin
            if (i < 4) rx_q.push_back(8'(8'h40 + i));
            send_frame(8'(8'h40 + i), 0, 1, 0);
        end
        rd(2'd3, 1'b0, v); chk("R6 overrun flag", v[2], 1'b1); chk("R5 full flag", v[6], 1'b1);
        for (int i = 0; i < 4; i++) read_rx("R6 stored bytes kept");
        set_ctrl(1, 1, 0, 0, 0, 0);
        rd(2'd3, 1'b0, v); chk("R11 overrun cleared", v[2], 1'b0);
        set_ctrl(1, 1, 0, 0, 0, 1);

        // R7 / R11: framing error and break
        rx_q.push_back(8'h5A); send_frame(8'h5A, 0, 0, 0);
        rd(2'd3, 1'b0, v); chk("R7 framing flag", v[3], 1'b1); chk("R11 no break", v[5], 1'b0);
        read_rx("R7 byte still stored");
        rx_q.push_back(8'h00); send_frame(8'h00, 0, 0, 0);
        rd(2'd3, 1'b0, v); chk("R11 break flag", v[5], 1'b1);
        read_rx("R11 break byte");
        set_ctrl(1, 1, 0, 0, 0, 0);
        rd(2'd3, 1'b0, v); chk("R11 errors cleared", v & 8'h2C, 8'h00);
        set_ctrl(1, 1, 1, 1, 0, 1);

        // R8 / R12: wake-up filter
        send_frame(8'h77, 0, 0, 1);
        rd(2'd3, 1'b0, v); chk("R8 dropped no data", v[0], 1'b0); chk("R8 dropped no flag", v[3], 1'b0);
        rx_q.push_back(8'h12); send_frame(8'h12, 1, 1, 1);
        read_rx("R8 address frame kept");
        rd(2'd2, 1'b0, v); chk("R12 last extra bit 1", v[4], 1'b1);

        // R9 / R12: filter off accepts data frames
        set_ctrl(1, 1, 1, 0, 0, 1);
        rx_q.push_back(8'h34); send_frame(8'h34, 0, 1, 1);
        read_rx("R9 data frame kept");
        rd(2'd2, 1'b0, v); chk("R12 last extra bit 0", v[4], 1'b0);

        // R10: abort mid-frame with a byte held
        set_ctrl(1, 1, 0, 0, 0, 1);
        mon_en = 1'b0;
        wr(2'd0, 8'hF0); repeat (3) @(negedge clk); wr(2'd0, 8'h0F);
        repeat (100) @(negedge clk);
        rd(2'd3, 1'b0, v); chk("R10 held before abort", v[1], 1'b0);
        set_ctrl(1, 0, 0, 0, 0, 1);
        chk("R10 line high after abort", txd, 1'b1);
        rd(2'd3, 1'b0, v); chk("R10 empty flag kept", v[1], 1'b0);
        begin
            bit hi = 1'b1;
            for (int i = 0; i < 100; i++) begin @(negedge clk); hi &= txd; end
            chk("R10 stays high while off", hi, 1'b1);
        end
        mon_en = 1'b1;
        tx_q.push_back({1'b0, 8'h0F});
        set_ctrl(1, 1, 0, 0, 0, 1);
        repeat (400) @(negedge clk);
        chk("R10 held byte sent after enable", tx_q.size(), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule